// File: doc/BRIEF.md
# Process-Tagged Translation Lookaside Buffer

This block is a small fully associative store of recent page translations. Each entry maps a virtual page number to a physical frame number and carries a writable flag. Each entry also carries the ID of the process that owns it. Because an entry only answers lookups from its own process, a context switch needs no flush. The 12-bit page offset of a 4 KB page never enters the block: the requester joins it to the returned frame number.

A lookup presents a page number, a process ID and a read/write flag. One clock later the block answers with exactly one of hit, miss or permission fault. On a miss, an external table walker fetches the translation and writes it in through the fill port. When the operating system changes the rights on a page, the purge port removes stale entries. It can remove a single page of one process, or every entry that belongs to one process.

Top module: `ptag_tlb`

## Requirements
- R1: After reset no entry is valid, no response is raised, and every lookup answers miss.
- R2: A lookup accepted at a clock edge yields respValid at the following edge, with exactly one of respHit, respMiss and respFault set. No response appears without a lookup. On a miss or a fault, respFrame and respWritable read zero.
- R3: A hit requires a valid entry whose stored page number and process ID both equal the lookup's. The hit returns that entry's frame number and writable flag.
- R4: A write lookup (lookupWrite=1) that matches an entry with writable=0 answers fault and not hit. A read lookup of the same entry answers hit.
- R5: A fill whose page number and process ID equal those of a valid entry rewrites that entry in place, so one tag never occupies two entries.
- R6: Any other fill goes to the lowest-numbered invalid entry.
- R7: When no entry is invalid, a fill replaces the entry named by a replacement pointer. The pointer starts at 0 after reset and steps by one, wrapping after the last entry, only on such fills.
- R8: A page purge (purgeMode=0) invalidates only entries whose page number and process ID both match. All other entries stay.
- R9: A process purge (purgeMode=1) invalidates every entry with the given process ID, whatever its page number.
- R10: A purge and a fill in the same cycle apply the purge first. A slot freed by the purge can take the fill, and a fill of the purged tag survives.
- R11: A lookup is answered from the contents held before the fill or purge of that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| lookupValid | input | 1 | Lookup request this cycle |
| lookupVpn | input | VPN_W | Virtual page number to translate |
| lookupPid | input | PID_W | Current process ID |
| lookupWrite | input | 1 | 1 for a write access, 0 for a read |
| fillValid | input | 1 | Install a translation this cycle |
| fillVpn | input | VPN_W | Page number of the translation |
| fillPid | input | PID_W | Owning process ID |
| fillFrame | input | PFN_W | Physical frame number |
| fillWritable | input | 1 | Write permission of the page |
| purgeValid | input | 1 | Purge request this cycle |
| purgeMode | input | 1 | 0 page purge, 1 process purge |
| purgeVpn | input | VPN_W | Page number for a page purge |
| purgePid | input | PID_W | Process ID to purge |
| respValid | output | 1 | Response to the previous cycle's lookup |
| respHit | output | 1 | Translation found and access allowed |
| respMiss | output | 1 | No matching entry |
| respFault | output | 1 | Write to a read-only page |
| respFrame | output | PFN_W | Frame number on a hit, else zero |
| respWritable | output | 1 | Writable flag on a hit, else zero |

## Verification
Several properties are checked on every cycle: the one-cycle response timing and the one-hot response kind; that at most one entry matches any lookup; that a fault only follows a write; that a purge without a same-cycle fill leaves none of its matched entries valid; and that the valid count never grows without a fill. Other behaviour is only visible through the bench's scenarios, because it depends on history. That covers where fills land, including the lowest-free choice, the pointer order and its wrap, and the rewrite of a resident tag in place. It also covers purge-before-fill ordering, tag separation between processes, and which contents a same-cycle lookup sees.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  parameter int TLB_ENTRIES = 8;

  typedef enum logic {
    PURGE_PAGE = 1'b0,
    PURGE_PROC = 1'b1
  } purge_mode_e;

  // Strobes from control to datapath, one bit per entry
  typedef struct packed {
    logic [TLB_ENTRIES-1:0] clearMask;
    logic [TLB_ENTRIES-1:0] writeMask;
  } tlb_strobe_t;
endpackage

// File: rtl/tlb_ctrl.sv
module tlb_ctrl
  import tlb_pkg::*;
(
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   fillValid,
  input  logic                   purgeValid,
  input  logic [TLB_ENTRIES-1:0] validVec,
  input  logic [TLB_ENTRIES-1:0] purgeHitVec,
  input  logic [TLB_ENTRIES-1:0] fillSameVec,
  output tlb_strobe_t            strobe
);
  localparam int IDX_W = (TLB_ENTRIES > 1) ? $clog2(TLB_ENTRIES) : 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(TLB_ENTRIES - 1);

  logic [IDX_W-1:0]       rrPtr;
  logic [TLB_ENTRIES-1:0] validAfter;
  logic [TLB_ENTRIES-1:0] sameAfter;
  logic [TLB_ENTRIES-1:0] firstFree;
  logic                   anyFree;
  logic                   useRr;

  always_comb begin
    // purge takes effect before the fill is placed
    strobe.clearMask = purgeValid ? purgeHitVec : '0;
    validAfter = validVec & ~strobe.clearMask;
    sameAfter  = fillSameVec & ~strobe.clearMask;
    firstFree  = '0;
    anyFree    = 1'b0;
    for (int i = 0; i < TLB_ENTRIES; i++) begin
      if (!validAfter[i] && !anyFree) begin
        firstFree[i] = 1'b1;
        anyFree      = 1'b1;
      end
    end
    useRr            = 1'b0;
    strobe.writeMask = '0;
    if (fillValid) begin
      if (|sameAfter) begin
        strobe.writeMask = sameAfter;
      end else if (anyFree) begin
        strobe.writeMask = firstFree;
      end else begin
        for (int i = 0; i < TLB_ENTRIES; i++) begin
          strobe.writeMask[i] = (rrPtr == IDX_W'(i));
        end
        useRr = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rrPtr <= '0;
    end else if (useRr) begin
      rrPtr <= (rrPtr == LAST_IDX) ? '0 : rrPtr + 1'b1;
    end
  end
endmodule

// File: rtl/tlb_datapath.sv
module tlb_datapath
  import tlb_pkg::*;
#(
  parameter int PID_W = 8,
  parameter int VPN_W = 20,
  parameter int PFN_W = 24
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   lookupValid,
  input  logic [VPN_W-1:0]       lookupVpn,
  input  logic [PID_W-1:0]       lookupPid,
  input  logic                   lookupWrite,
  input  logic [VPN_W-1:0]       fillVpn,
  input  logic [PID_W-1:0]       fillPid,
  input  logic [PFN_W-1:0]       fillFrame,
  input  logic                   fillWritable,
  input  logic                   purgeMode,
  input  logic [VPN_W-1:0]       purgeVpn,
  input  logic [PID_W-1:0]       purgePid,
  input  tlb_strobe_t            strobe,
  output logic [TLB_ENTRIES-1:0] validVec,
  output logic [TLB_ENTRIES-1:0] lookupHitVec,
  output logic [TLB_ENTRIES-1:0] purgeHitVec,
  output logic [TLB_ENTRIES-1:0] fillSameVec,
  output logic                   respValid,
  output logic                   respHit,
  output logic                   respMiss,
  output logic                   respFault,
  output logic [PFN_W-1:0]       respFrame,
  output logic                   respWritable
);
  logic             validQ [TLB_ENTRIES];
  logic [PID_W-1:0] pidQ   [TLB_ENTRIES];
  logic [VPN_W-1:0] vpnQ   [TLB_ENTRIES];
  logic [PFN_W-1:0] frameQ [TLB_ENTRIES];
  logic             wrQ    [TLB_ENTRIES];

  for (genvar g = 0; g < TLB_ENTRIES; g++) begin : gEntry
    assign validVec[g]     = validQ[g];
    assign lookupHitVec[g] = validQ[g] && (pidQ[g] == lookupPid) && (vpnQ[g] == lookupVpn);
    assign purgeHitVec[g]  = validQ[g] && (pidQ[g] == purgePid) &&
                             ((purgeMode == PURGE_PROC) || (vpnQ[g] == purgeVpn));
    assign fillSameVec[g]  = validQ[g] && (pidQ[g] == fillPid) && (vpnQ[g] == fillVpn);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        validQ[g] <= 1'b0;
      end else if (strobe.writeMask[g]) begin
        validQ[g] <= 1'b1;
      end else if (strobe.clearMask[g]) begin
        validQ[g] <= 1'b0;
      end
    end

    always_ff @(posedge clk) begin
      if (strobe.writeMask[g]) begin
        pidQ[g]   <= fillPid;
        vpnQ[g]   <= fillVpn;
        frameQ[g] <= fillFrame;
        wrQ[g]    <= fillWritable;
      end
    end
  end

  logic [PFN_W-1:0] selFrame;
  logic             selWr;
  logic             anyHit;
  logic             denied;

  always_comb begin
    selFrame = '0;
    selWr    = 1'b0;
    for (int i = 0; i < TLB_ENTRIES; i++) begin
      if (lookupHitVec[i]) begin
        selFrame = selFrame | frameQ[i];
        selWr    = selWr | wrQ[i];
      end
    end
    anyHit = |lookupHitVec;
    denied = lookupWrite && !selWr;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      respValid    <= 1'b0;
      respHit      <= 1'b0;
      respMiss     <= 1'b0;
      respFault    <= 1'b0;
      respFrame    <= '0;
      respWritable <= 1'b0;
    end else begin
      respValid    <= lookupValid;
      respHit      <= lookupValid && anyHit && !denied;
      respMiss     <= lookupValid && !anyHit;
      respFault    <= lookupValid && anyHit && denied;
      respFrame    <= (lookupValid && anyHit && !denied) ? selFrame : '0;
      respWritable <= lookupValid && anyHit && !denied && selWr;
    end
  end
endmodule

// File: rtl/ptag_tlb.sv
module ptag_tlb
  import tlb_pkg::*;
#(
  parameter int PID_W = 8,
  parameter int VPN_W = 20,
  parameter int PFN_W = 24
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             lookupValid,
  input  logic [VPN_W-1:0] lookupVpn,
  input  logic [PID_W-1:0] lookupPid,
  input  logic             lookupWrite,
  input  logic             fillValid,
  input  logic [VPN_W-1:0] fillVpn,
  input  logic [PID_W-1:0] fillPid,
  input  logic [PFN_W-1:0] fillFrame,
  input  logic             fillWritable,
  input  logic             purgeValid,
  input  logic             purgeMode,
  input  logic [VPN_W-1:0] purgeVpn,
  input  logic [PID_W-1:0] purgePid,
  output logic             respValid,
  output logic             respHit,
  output logic             respMiss,
  output logic             respFault,
  output logic [PFN_W-1:0] respFrame,
  output logic             respWritable
);
  tlb_strobe_t            strobe;
  logic [TLB_ENTRIES-1:0] validVec;
  logic [TLB_ENTRIES-1:0] lookupHitVec;
  logic [TLB_ENTRIES-1:0] purgeHitVec;
  logic [TLB_ENTRIES-1:0] fillSameVec;

  tlb_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .fillValid(fillValid), .purgeValid(purgeValid),
    .validVec(validVec), .purgeHitVec(purgeHitVec), .fillSameVec(fillSameVec),
    .strobe(strobe)
  );

  tlb_datapath #(.PID_W(PID_W), .VPN_W(VPN_W), .PFN_W(PFN_W)) uData (
    .clk(clk), .rstN(rstN),
    .lookupValid(lookupValid), .lookupVpn(lookupVpn), .lookupPid(lookupPid),
    .lookupWrite(lookupWrite),
    .fillVpn(fillVpn), .fillPid(fillPid), .fillFrame(fillFrame), .fillWritable(fillWritable),
    .purgeMode(purgeMode), .purgeVpn(purgeVpn), .purgePid(purgePid),
    .strobe(strobe),
    .validVec(validVec), .lookupHitVec(lookupHitVec), .purgeHitVec(purgeHitVec),
    .fillSameVec(fillSameVec),
    .respValid(respValid), .respHit(respHit), .respMiss(respMiss), .respFault(respFault),
    .respFrame(respFrame), .respWritable(respWritable)
  );
endmodule

// File: rtl/tlb_checker.sv
module tlb_checker
  import tlb_pkg::*;
(
  input logic                   clk,
  input logic                   rstN,
  input logic                   lookupValid,
  input logic                   lookupWrite,
  input logic                   fillValid,
  input logic                   purgeValid,
  input logic                   respValid,
  input logic                   respHit,
  input logic                   respMiss,
  input logic                   respFault,
  input logic [TLB_ENTRIES-1:0] validVec,
  input logic [TLB_ENTRIES-1:0] lookupHitVec,
  input logic [TLB_ENTRIES-1:0] purgeHitVec
);
  assert_resp_follows_R2: assert property (@(posedge clk) disable iff (!rstN)
    lookupValid |=> respValid);

  assert_no_idle_resp_R2: assert property (@(posedge clk) disable iff (!rstN)
    !lookupValid |=> !respValid);

  assert_kind_onehot_R2: assert property (@(posedge clk) disable iff (!rstN)
    respValid |-> ($countones({respHit, respMiss, respFault}) == 1));

  assert_kind_quiet_R2: assert property (@(posedge clk) disable iff (!rstN)
    !respValid |-> !(respHit || respMiss || respFault));

  assert_unique_match_R5: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(lookupHitVec));

  assert_fault_needs_write_R4: assert property (@(posedge clk) disable iff (!rstN)
    (lookupValid && !lookupWrite) |=> !respFault);

  assert_purge_clears_R8: assert property (@(posedge clk) disable iff (!rstN)
    (purgeValid && !fillValid) |=> ((validVec & $past(purgeHitVec)) == '0));

  assert_no_spurious_valid_R6: assert property (@(posedge clk) disable iff (!rstN)
    !fillValid |=> ($countones(validVec) <= $past($countones(validVec))));
endmodule

bind ptag_tlb tlb_checker uChk (
  .clk(clk), .rstN(rstN), .lookupValid(lookupValid), .lookupWrite(lookupWrite),
  .fillValid(fillValid), .purgeValid(purgeValid),
  .respValid(respValid), .respHit(respHit), .respMiss(respMiss), .respFault(respFault),
  .validVec(validVec), .lookupHitVec(lookupHitVec), .purgeHitVec(purgeHitVec)
);

// File: tb/tb_ptag_tlb.sv
module tb_ptag_tlb;
  localparam int PID_W = 8;
  localparam int VPN_W = 20;
  localparam int PFN_W = 24;

  typedef enum int { K_MISS = 0, K_HIT = 1, K_FAULT = 2 } kind_e;
  typedef struct {
    kind_e            kind;
    logic [PFN_W-1:0] frame;
    logic             wr;
    string            tag;
  } exp_t;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic lookupValid = 0, lookupWrite = 0, fillValid = 0, fillWritable = 0;
  logic purgeValid = 0, purgeMode = 0;
  logic [VPN_W-1:0] lookupVpn = '0, fillVpn = '0, purgeVpn = '0;
  logic [PID_W-1:0] lookupPid = '0, fillPid = '0, purgePid = '0;
  logic [PFN_W-1:0] fillFrame = '0;
  logic respValid, respHit, respMiss, respFault, respWritable;
  logic [PFN_W-1:0] respFrame;

  int vectors = 0;
  int miscompares = 0;
  int cycles = 0;
  bit done = 0;
  exp_t expQ[$];

  always #10 clk = ~clk;

  ptag_tlb #(.PID_W(PID_W), .VPN_W(VPN_W), .PFN_W(PFN_W)) dut (
    .clk(clk), .rstN(rstN),
    .lookupValid(lookupValid), .lookupVpn(lookupVpn), .lookupPid(lookupPid),
    .lookupWrite(lookupWrite),
    .fillValid(fillValid), .fillVpn(fillVpn), .fillPid(fillPid), .fillFrame(fillFrame),
    .fillWritable(fillWritable),
    .purgeValid(purgeValid), .purgeMode(purgeMode), .purgeVpn(purgeVpn), .purgePid(purgePid),
    .respValid(respValid), .respHit(respHit), .respMiss(respMiss), .respFault(respFault),
    .respFrame(respFrame), .respWritable(respWritable)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
    end
  endtask

  // Monitor: pops the scoreboard whenever a response appears
  always @(negedge clk) begin
    if (rstN && !done && respValid) begin
      if (expQ.size() == 0) begin
        check(1'b0, "R2", "unexpected response", 1, 0);
      end else begin
        exp_t e;
        int actKind;
        e = expQ.pop_front();
        actKind = respHit ? 1 : (respFault ? 2 : (respMiss ? 0 : -1));
        check({respHit, respMiss, respFault} == {e.kind == K_HIT, e.kind == K_MISS, e.kind == K_FAULT},
              e.tag, "kind", actKind, e.kind);
        check(respFrame == e.frame && respWritable == e.wr, e.tag, "frame/writable",
              {respFrame, respWritable}, {e.frame, e.wr});
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      miscompares++;
      $display("FAIL watchdog: actual %0d cycles expected under 20000", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  task automatic tick();
    @(negedge clk);
    lookupValid = 0;
    fillValid   = 0;
    purgeValid  = 0;
  endtask

  task automatic setLookup(input logic [VPN_W-1:0] vpn, input logic [PID_W-1:0] pid,
                           input logic wr, input kind_e kind, input logic [PFN_W-1:0] frame,
                           input logic ewr, input string tag);
    exp_t e;
    lookupValid = 1; lookupVpn = vpn; lookupPid = pid; lookupWrite = wr;
    e.kind = kind; e.frame = frame; e.wr = ewr; e.tag = tag;
    expQ.push_back(e);
  endtask

  task automatic setFill(input logic [VPN_W-1:0] vpn, input logic [PID_W-1:0] pid,
                         input logic [PFN_W-1:0] frame, input logic wr);
    fillValid = 1; fillVpn = vpn; fillPid = pid; fillFrame = frame; fillWritable = wr;
  endtask

  task automatic setPurge(input logic mode, input logic [VPN_W-1:0] vpn,
                          input logic [PID_W-1:0] pid);
    purgeValid = 1; purgeMode = mode; purgeVpn = vpn; purgePid = pid;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R1: quiet after reset
    check(!respValid && !respHit && !respMiss && !respFault, "R1", "reset outputs",
          {respValid, respHit, respMiss, respFault}, 0);
    setLookup(20'h10, 8'd1, 0, K_MISS, 0, 0, "R1"); tick();
    tick();
    // R2: no response without a lookup
    check(!respValid, "R2", "idle response", respValid, 0);

    setFill(20'h10, 8'd1, 24'hABC01, 1); tick();   // slot 0
    setFill(20'h10, 8'd2, 24'h00222, 0); tick();   // slot 1
    setLookup(20'h10, 8'd1, 0, K_HIT, 24'hABC01, 1, "R3"); tick();
    setLookup(20'h10, 8'd2, 0, K_HIT, 24'h00222, 0, "R4"); tick();
    setLookup(20'h10, 8'd3, 0, K_MISS, 0, 0, "R3"); tick();
    setLookup(20'h11, 8'd1, 0, K_MISS, 0, 0, "R3"); tick();
    setLookup(20'h10, 8'd2, 1, K_FAULT, 0, 0, "R4"); tick();
    setLookup(20'h10, 8'd1, 1, K_HIT, 24'hABC01, 1, "R4"); tick();

    // R11: same-cycle lookup sees old contents; R5: rewrite in place
    setFill(20'h10, 8'd1, 24'h00555, 0);
    setLookup(20'h10, 8'd1, 0, K_HIT, 24'hABC01, 1, "R11"); tick();
    setLookup(20'h10, 8'd1, 0, K_HIT, 24'h00555, 0, "R5"); tick();

    // R8: page purge leaves other process's copy alone
    setPurge(1'b0, 20'h10, 8'd1); tick();
    setLookup(20'h10, 8'd1, 0, K_MISS, 0, 0, "R8"); tick();
    setLookup(20'h10, 8'd2, 0, K_HIT, 24'h00222, 0, "R8"); tick();

    // R6/R7: slot 0 free, slot 1 used; 7 fills fill the free slots, 8th uses pointer 0
    for (int k = 0; k < 8; k++) begin
      setFill(20'h100 + VPN_W'(k), 8'd5, 24'h1000 + PFN_W'(k), 1); tick();
    end
    setLookup(20'h100, 8'd5, 0, K_MISS, 0, 0, "R7"); tick();
    setLookup(20'h107, 8'd5, 0, K_HIT, 24'h1007, 1, "R7"); tick();
    setLookup(20'h101, 8'd5, 0, K_HIT, 24'h1001, 1, "R6"); tick();
    setLookup(20'h10, 8'd2, 0, K_HIT, 24'h00222, 0, "R7"); tick();
    setFill(20'h108, 8'd5, 24'h1008, 1); tick();   // pointer 1 replaces slot 1
    setLookup(20'h10, 8'd2, 0, K_MISS, 0, 0, "R7"); tick();
    setLookup(20'h108, 8'd5, 0, K_HIT, 24'h1008, 1, "R7"); tick();
    setLookup(20'h106, 8'd5, 0, K_HIT, 24'h1006, 1, "R7"); tick();

    // R9 + R10: process purge with a fill in the same cycle
    setPurge(1'b1, 20'h0, 8'd5); setFill(20'h200, 8'd9, 24'h2000, 0); tick();
    setLookup(20'h107, 8'd5, 0, K_MISS, 0, 0, "R9"); tick();
    setLookup(20'h103, 8'd5, 0, K_MISS, 0, 0, "R9"); tick();
    setLookup(20'h108, 8'd5, 0, K_MISS, 0, 0, "R9"); tick();
    setLookup(20'h200, 8'd9, 0, K_HIT, 24'h2000, 0, "R10"); tick();
    // R10: fill of the purged tag survives the purge
    setPurge(1'b0, 20'h200, 8'd9); setFill(20'h200, 8'd9, 24'h00777, 1); tick();
    setLookup(20'h200, 8'd9, 1, K_HIT, 24'h00777, 1, "R10"); tick();

    repeat (3) tick();
    check(expQ.size() == 0, "R2", "responses outstanding", expQ.size(), 0);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule